// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits inside a behavioural NOR flash model and watches the host's bus write cycles. Each cycle in which the write strobe is high presents an address and a data word. The block recognises the multi-cycle command sequences that start an embedded program, a sector erase or a full chip erase. For each one it emits a single-cycle start pulse, and a program or sector start carries the captured address and data. The flash array, the embedded algorithms and status polling sit outside this block.

Besides the normal mode, which is guarded by two unlock writes, the decoder has a bypass mode. In bypass mode a program takes two writes and an erase takes four, and every write outside that small command set is ignored. The host enters bypass mode with a command and leaves it with a two-write exit. An accelerate input also forces bypass mode while it is held high. A busy input from the embedded algorithm engine causes every write to be ignored, so no start pulse can be issued while an operation is still running.

The unlock writes carry data AAh at address 555h, then data 55h at address 2AAh. Only the low 12 address bits are compared in the default decode variant. Command codes sit in data bits [7:0]: A0h program set-up, 80h erase set-up, 10h chip erase (at 555h), 30h sector erase (at the sector address), 20h bypass entry (at 555h), 90h and then 00h for bypass exit.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, prog_start, sect_erase_start and chip_erase_start are low and bypass_mode is low while accel is low.
- R2: In normal mode, the writes AAh@555h, 55h@2AAh and A0h@555h followed by any address/data write raise prog_start for one cycle, in the cycle after that last write, with prog_addr and prog_data equal to it. The unlock addresses compare only address bits [11:0].
- R3: In normal mode, AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise chip_erase_start for one cycle after the sixth write, with no other start pulse.
- R4: The same six-write sequence ending in 30h at any address raises sect_erase_start after the last write, with erase_addr equal to that address.
- R5: In normal mode, a write that does not match the next expected step returns the decoder to idle without any pulse. The rest of the broken sequence then produces nothing.
- R6: In normal mode, AAh@555h, 55h@2AAh, 20h@555h sets bypass_mode high in the cycle after the third write.
- R7: In bypass mode, A0h at any address followed by an address/data write produces the program pulse with that address and data.
- R8: In bypass mode, 80h at any address, AAh@555h, 55h@2AAh, then 10h@555h or 30h at the sector address produce the chip or sector erase pulse.
- R9: In bypass mode, a write other than A0h, 80h or 90h from idle is ignored: bypass_mode stays high and a following address/data write gives no pulse.
- R10: In bypass mode, 90h followed by 00h clears bypass_mode in the cycle after the 00h write. 90h followed by any other data leaves bypass_mode high. After the exit, a lone A0h write followed by a data write gives no pulse.
- R11: While accel is high, bypass_mode is high in the same cycle and the bypass sequences work. When accel falls, bypass_mode returns to the mode set by commands. The write in the cycle where accel changes is ignored, and the sequence restarts from idle.
- R12: A write while busy is high is ignored and does not break a sequence in progress, and no start pulse appears in the cycle after a busy cycle.
- R13: Start pulses last exactly one cycle and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle when high |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data, command code in bits [7:0] |
| busy | input | 1 | Embedded operation running; writes ignored |
| accel | input | 1 | Forces bypass mode while high |
| prog_start | output | 1 | One-cycle program start pulse |
| prog_addr | output | AW | Address captured with the program start |
| prog_data | output | DW | Data captured with the program start |
| sect_erase_start | output | 1 | One-cycle sector erase start pulse |
| chip_erase_start | output | 1 | One-cycle chip erase start pulse |
| erase_addr | output | AW | Sector address captured with the sector erase start |
| bypass_mode | output | 1 | High while bypass mode is in effect |

## Verification
The hardest case to reach from the ports is a busy interval that lands in the middle of a partly decoded sequence. A busy write there must neither advance nor reset the sequence, and only the bus can show this. The bench walks the sequence up to its data write, raises busy across a disturbing write, then finishes the sequence and expects the pulse to carry the post-busy data. A second hard case is accel toggling while the decoder sits in a bypass-only state. The bench brings it about with a directed accel edge between an erase set-up and its follow-up writes. Constrained random runs of complete, aborted and garbage-prefixed commands in both modes cover the rest.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNL1,
      ST_UNL2,
      ST_PROG,
      ST_ERS1,
      ST_ERS2,
      ST_ERS3,
      ST_EXIT1
   } seq_state_t;

   localparam logic [7:0] CD_UNLK_A      = 8'hAA;
   localparam logic [7:0] CD_UNLK_B      = 8'h55;
   localparam logic [7:0] CD_ERASE_SETUP = 8'h80;
   localparam logic [7:0] CD_CHIP        = 8'h10;
   localparam logic [7:0] CD_SECTOR      = 8'h30;
   localparam logic [7:0] CD_PROG        = 8'hA0;
   localparam logic [7:0] CD_BYP_ENTER   = 8'h20;
   localparam logic [7:0] CD_BYP_EXIT1   = 8'h90;
   localparam logic [7:0] CD_BYP_EXIT2   = 8'h00;

   localparam int UNLK_ADDR_A = 'h555;
   localparam int UNLK_ADDR_B = 'h2AA;
   localparam int UNLK_MIN_BITS = 11;

   typedef struct packed {
      logic at_a;
      logic at_b;
      logic is_aa;
      logic is_55;
      logic is_80;
      logic is_10;
      logic is_30;
      logic is_a0;
      logic is_20;
      logic is_90;
      logic is_00;
   } cmd_class_t;

endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match
   import nor_cmd_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int UNLK_BITS   = 12,
   parameter bit FULL_DECODE = 1'b0
) (
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output cmd_class_t    cls
);

   localparam int CW = 8;

   logic [CW-1:0] code;
   assign code = data[CW-1:0];

   generate
      if (UNLK_BITS < UNLK_MIN_BITS || UNLK_BITS > AW) begin : g_bad_bits
         $error("nor_cmd_match: UNLK_BITS out of range");
      end
      if (DW < CW) begin : g_bad_dw
         $error("nor_cmd_match: DW must hold a command byte");
      end

      if (FULL_DECODE) begin : g_full
         assign cls.at_a = (addr == AW'(UNLK_ADDR_A));
         assign cls.at_b = (addr == AW'(UNLK_ADDR_B));
      end else begin : g_low
         assign cls.at_a = (addr[UNLK_BITS-1:0] == UNLK_BITS'(UNLK_ADDR_A));
         assign cls.at_b = (addr[UNLK_BITS-1:0] == UNLK_BITS'(UNLK_ADDR_B));
         if (AW > UNLK_BITS) begin : g_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^addr[AW-1:UNLK_BITS];
         end
      end

      if (DW > CW) begin : g_dhi
         logic unused_data_hi;
         assign unused_data_hi = ^data[DW-1:CW];
      end
   endgenerate

   assign cls.is_aa = (code == CD_UNLK_A);
   assign cls.is_55 = (code == CD_UNLK_B);
   assign cls.is_80 = (code == CD_ERASE_SETUP);
   assign cls.is_10 = (code == CD_CHIP);
   assign cls.is_30 = (code == CD_SECTOR);
   assign cls.is_a0 = (code == CD_PROG);
   assign cls.is_20 = (code == CD_BYP_ENTER);
   assign cls.is_90 = (code == CD_BYP_EXIT1);
   assign cls.is_00 = (code == CD_BYP_EXIT2);

endmodule

// File: rtl/nor_cmd_mode.sv
module nor_cmd_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic accel,
   input  logic bp_set,
   input  logic bp_clr,
   output logic bypass_mode,
   output logic mode_chg
);

   logic bp_q;
   logic accel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_q    <= 1'b0;
         accel_q <= 1'b0;
      end else begin
         accel_q <= accel;
         if (bp_set) begin
            bp_q <= 1'b1;
         end else if (bp_clr) begin
            bp_q <= 1'b0;
         end
      end
   end

   assign bypass_mode = bp_q | accel;
   assign mode_chg    = accel ^ accel_q;

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_cmd_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          busy,
   input  logic          mode_chg,
   input  logic          bypass,
   input  cmd_class_t    cls,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic          prog_start,
   output logic [AW-1:0] prog_addr,
   output logic [DW-1:0] prog_data,
   output logic          sect_start,
   output logic          chip_start,
   output logic [AW-1:0] erase_addr,
   output logic          bp_set,
   output logic          bp_clr
);

   seq_state_t st, nxt;
   logic       acc;
   logic       go_prog, go_sect, go_chip;

   assign acc = wr_en & ~busy & ~mode_chg;

   always_comb begin
      nxt     = st;
      go_prog = 1'b0;
      go_sect = 1'b0;
      go_chip = 1'b0;
      bp_set  = 1'b0;
      bp_clr  = 1'b0;
      if (acc) begin
         nxt = ST_IDLE;
         case (st)
            ST_IDLE: begin
               if (!bypass) begin
                  if (cls.at_a && cls.is_aa) nxt = ST_UNL1;
               end else if (cls.is_a0) begin
                  nxt = ST_PROG;
               end else if (cls.is_80) begin
                  nxt = ST_ERS1;
               end else if (cls.is_90) begin
                  nxt = ST_EXIT1;
               end
            end
            ST_UNL1: if (cls.at_b && cls.is_55) nxt = ST_UNL2;
            ST_UNL2: begin
               if (cls.at_a) begin
                  if (cls.is_a0) nxt = ST_PROG;
                  else if (cls.is_80) nxt = ST_ERS1;
                  else if (cls.is_20) bp_set = 1'b1;
               end
            end
            ST_PROG: go_prog = 1'b1;
            ST_ERS1: if (cls.at_a && cls.is_aa) nxt = ST_ERS2;
            ST_ERS2: if (cls.at_b && cls.is_55) nxt = ST_ERS3;
            ST_ERS3: begin
               if (cls.at_a && cls.is_10) go_chip = 1'b1;
               else if (cls.is_30) go_sect = 1'b1;
            end
            ST_EXIT1: if (cls.is_00) bp_clr = 1'b1;
            default: nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         prog_start <= 1'b0;
         sect_start <= 1'b0;
         chip_start <= 1'b0;
         prog_addr  <= '0;
         prog_data  <= '0;
         erase_addr <= '0;
      end else begin
         st         <= mode_chg ? ST_IDLE : nxt;
         prog_start <= go_prog;
         sect_start <= go_sect;
         chip_start <= go_chip;
         if (go_prog) begin
            prog_addr <= addr;
            prog_data <= data;
         end
         if (go_sect) begin
            erase_addr <= addr;
         end
      end
   end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
   import nor_cmd_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int UNLK_BITS   = 12,
   parameter bit FULL_DECODE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          busy,
   input  logic          accel,
   output logic          prog_start,
   output logic [AW-1:0] prog_addr,
   output logic [DW-1:0] prog_data,
   output logic          sect_erase_start,
   output logic          chip_erase_start,
   output logic [AW-1:0] erase_addr,
   output logic          bypass_mode
);

   cmd_class_t cls;
   logic       bp_set, bp_clr, mode_chg;

   nor_cmd_match #(
      .AW(AW), .DW(DW), .UNLK_BITS(UNLK_BITS), .FULL_DECODE(FULL_DECODE)
   ) match_i (
      .addr (wr_addr),
      .data (wr_data),
      .cls  (cls)
   );

   nor_cmd_mode mode_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .accel       (accel),
      .bp_set      (bp_set),
      .bp_clr      (bp_clr),
      .bypass_mode (bypass_mode),
      .mode_chg    (mode_chg)
   );

   nor_cmd_seq #(.AW(AW), .DW(DW)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .busy       (busy),
      .mode_chg   (mode_chg),
      .bypass     (bypass_mode),
      .cls        (cls),
      .addr       (wr_addr),
      .data       (wr_data),
      .prog_start (prog_start),
      .prog_addr  (prog_addr),
      .prog_data  (prog_data),
      .sect_start (sect_erase_start),
      .chip_start (chip_erase_start),
      .erase_addr (erase_addr),
      .bp_set     (bp_set),
      .bp_clr     (bp_clr)
   );

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [DW-1:0] wr_data,
   input logic          busy,
   input logic          accel,
   input logic          prog_start,
   input logic          sect_erase_start,
   input logic          chip_erase_start,
   input logic          bypass_mode
);

   logic any_start;
   assign any_start = prog_start | sect_erase_start | chip_erase_start;

   AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_start, sect_erase_start, chip_erase_start})); // R13

   AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start); // R13

   AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sect_erase_start | chip_erase_start) |=> !(sect_erase_start | chip_erase_start)); // R13

   AST_NO_WRITE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !any_start); // R2

   AST_BUSY_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !any_start); // R12

   AST_ACCEL_FORCES_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      accel |-> bypass_mode); // R11

   AST_BYPASS_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bypass_mode) |-> ($rose(accel) ||
         ($past(wr_en) && !$past(busy) && $past(wr_data[7:0]) == 8'h20))); // R6

   AST_BYPASS_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bypass_mode) |-> ($fell(accel) ||
         ($past(wr_en) && !$past(busy) && $past(wr_data[7:0]) == 8'h00))); // R10

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.DW(DW)) chk_i (
   .clk              (clk),
   .rst_n            (rst_n),
   .wr_en            (wr_en),
   .wr_data          (wr_data),
   .busy             (busy),
   .accel            (accel),
   .prog_start       (prog_start),
   .sect_erase_start (sect_erase_start),
   .chip_erase_start (chip_erase_start),
   .bypass_mode      (bypass_mode)
);

// File: tb/nor_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_decoder_tb_top;

   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          busy = 1'b0;
   logic          accel = 1'b0;
   logic          prog_start, sect_erase_start, chip_erase_start, bypass_mode;
   logic [AW-1:0] prog_addr, erase_addr;
   logic [DW-1:0] prog_data;

   int n_chk = 0;
   int n_fail = 0;
   logic seen_p, seen_s, seen_c;

   always #2.5 clk = ~clk;

   nor_cmd_decoder #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .accel(accel),
      .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
      .sect_erase_start(sect_erase_start), .chip_erase_start(chip_erase_start),
      .erase_addr(erase_addr), .bypass_mode(bypass_mode)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      seen_p = prog_start; seen_s = sect_erase_start; seen_c = chip_erase_start;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [2:0] exp_pulse(input int op);
      // {prog, sect, chip}
      case (op)
         0: return 3'b100;
         1: return 3'b001;
         2: return 3'b010;
         default: return 3'b000;
      endcase
   endfunction

   task automatic seq_prog(input bit byp, input logic [AW-1:0] a, input logic [DW-1:0] d);
      if (!byp) begin
         wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h00A0);
      end else begin
         wr(AW'($urandom), 16'h00A0);
      end
      wr(a, d);
   endtask

   task automatic seq_erase(input bit byp, input bit chip, input logic [AW-1:0] sa);
      if (!byp) begin
         wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0080);
      end else begin
         wr(AW'($urandom), 16'h0080);
      end
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
      if (chip) wr(16'h0555, 16'h0010);
      else wr(sa, 16'h0030);
   endtask

   task automatic run_op(input bit byp, input int op, input string tag);
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [2:0]    e;
      a = AW'($urandom);
      d = DW'($urandom);
      e = exp_pulse(op);
      case (op)
         0: seq_prog(byp, a, d);
         1: seq_erase(byp, 1'b1, a);
         2: seq_erase(byp, 1'b0, a);
         default: begin
            if (!byp) begin
               if ($urandom % 2 == 1) wr(16'h0555, 16'h00AA);
               wr(16'h0000, 16'h0000);
               wr(a, {d[DW-1:8], 8'h01});
            end else begin
               wr(a, 16'h0090);
               wr(a, 16'h005A);
               chk(bypass_mode == 1'b1, "R10", "bypass after bad exit", bypass_mode, 1);
            end
         end
      endcase
      chk({seen_p, seen_s, seen_c} == e, tag, "pulse kind", {seen_p, seen_s, seen_c}, e);
      if (op == 0) begin
         chk(prog_addr == a, tag, "prog_addr", prog_addr, a);
         chk(prog_data == d, tag, "prog_data", prog_data, d);
      end
      if (op == 2) chk(erase_addr == a, tag, "erase_addr", erase_addr, a);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk({prog_start, sect_erase_start, chip_erase_start} == 3'b000, "R1", "pulses", 0, 0);
      chk(bypass_mode == 1'b0, "R1", "bypass_mode", bypass_mode, 0);

      // R2 directed program, then R13 one-cycle width
      seq_prog(1'b0, 16'hBEEF, 16'h1234);
      chk(seen_p == 1'b1, "R2", "prog_start", seen_p, 1);
      chk(prog_addr == 16'hBEEF && prog_data == 16'h1234, "R2", "prog addr/data",
          {prog_addr, prog_data}, 32'hBEEF1234);
      idle(1);
      chk(prog_start == 1'b0, "R13", "prog_start width", prog_start, 0);
      // R2 upper address bits not compared
      wr(16'h7555, 16'h00AA); wr(16'hF2AA, 16'h0055); wr(16'h3555, 16'h00A0);
      wr(16'h0042, 16'h4242);
      chk(seen_p == 1'b1 && prog_data == 16'h4242, "R2", "aliased unlock", seen_p, 1);

      // R3 chip erase, R4 sector erase
      seq_erase(1'b0, 1'b1, 16'h0000);
      chk({seen_p, seen_s, seen_c} == 3'b001, "R3", "chip erase", {seen_p, seen_s, seen_c}, 1);
      seq_erase(1'b0, 1'b0, 16'hA000);
      chk({seen_p, seen_s, seen_c} == 3'b010, "R4", "sector erase", {seen_p, seen_s, seen_c}, 2);
      chk(erase_addr == 16'hA000, "R4", "erase_addr", erase_addr, 16'hA000);

      // R5 broken sequences
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0081);
      wr(16'h1234, 16'h5678);
      chk(seen_p == 1'b0, "R5", "broken program", seen_p, 0);
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0080);
      wr(16'h0555, 16'h00AA); wr(16'h02AB, 16'h0055); wr(16'h0555, 16'h0010);
      chk(seen_c == 1'b0, "R5", "broken chip erase", seen_c, 0);

      // R12 busy mid-sequence
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
      busy = 1'b1;
      wr(16'h0000, 16'h00FF);
      busy = 1'b0;
      wr(16'h0555, 16'h00A0);
      busy = 1'b1;
      wr(16'h0077, 16'h9999);
      chk(seen_p == 1'b0, "R12", "no pulse while busy", seen_p, 0);
      busy = 1'b0;
      wr(16'h0088, 16'h1111);
      chk(seen_p == 1'b1 && prog_data == 16'h1111, "R12", "sequence held over busy",
          prog_data, 16'h1111);

      // random normal-mode operations
      for (int i = 0; i < 40; i++) begin
         run_op(1'b0, int'($urandom % 4), "R5");
      end

      // R6 bypass entry
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0020);
      chk(bypass_mode == 1'b1, "R6", "bypass entry", bypass_mode, 1);

      // R7, R8 directed bypass operations
      seq_prog(1'b1, 16'h0F0F, 16'hCAFE);
      chk(seen_p == 1'b1 && prog_data == 16'hCAFE, "R7", "bypass program", prog_data, 16'hCAFE);
      seq_erase(1'b1, 1'b1, 16'h0000);
      chk(seen_c == 1'b1, "R8", "bypass chip erase", seen_c, 1);
      seq_erase(1'b1, 1'b0, 16'h5000);
      chk(seen_s == 1'b1 && erase_addr == 16'h5000, "R8", "bypass sector erase", erase_addr, 16'h5000);

      // R9 ignored writes in bypass
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0020);
      wr(16'h0100, 16'h1234);
      chk(seen_p == 1'b0, "R9", "ignored writes", seen_p, 0);
      chk(bypass_mode == 1'b1, "R9", "bypass kept", bypass_mode, 1);

      // random bypass-mode operations
      for (int i = 0; i < 40; i++) begin
         run_op(1'b1, int'($urandom % 4), "R8");
      end

      // R10 exit
      wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0012);
      chk(bypass_mode == 1'b1, "R10", "non-zero second write", bypass_mode, 1);
      wr(16'h0000, 16'h0090); wr(16'h3333, 16'h0000);
      chk(bypass_mode == 1'b0, "R10", "bypass exit", bypass_mode, 0);
      wr(16'h0000, 16'h00A0); wr(16'h0101, 16'h2222);
      chk(seen_p == 1'b0, "R10", "bypass program after exit", seen_p, 0);

      // R11 accelerate input
      accel = 1'b1; #1;
      chk(bypass_mode == 1'b1, "R11", "accel forces bypass", bypass_mode, 1);
      idle(1);
      seq_prog(1'b1, 16'h0202, 16'h3030);
      chk(seen_p == 1'b1 && prog_data == 16'h3030, "R11", "accel program", prog_data, 16'h3030);
      wr(16'h0000, 16'h0080);
      accel = 1'b0; #1;
      chk(bypass_mode == 1'b0, "R11", "accel release", bypass_mode, 0);
      idle(1);
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0010);
      chk(seen_c == 1'b0, "R11", "sequence restarted on accel edge", seen_c, 0);
      seq_prog(1'b0, 16'h0303, 16'h4040);
      chk(seen_p == 1'b1, "R11", "normal program after accel", seen_p, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule